// File: doc/BRIEF.md
# Raster Timing and Vertical-Blank Interrupt Generator

This block keeps the horizontal dot counter and the scanline counter of a tile-based video controller. From their position it drives a vertical-blank flag in a status byte and a one-clock non-maskable interrupt request for the host processor. Each clock edge handles the raster position currently shown on the `dot` and `scanline` outputs and then steps to the next position. A frame ends on a pre-render line, which is the last line of the frame.

The host side has three parts: a control-write strobe with its data byte, a status-read strobe, and the status byte as a combinational output. A read sees the status as it stands in the cycle the strobe is high, and the read takes effect at the next edge. Two races near the start of vertical blank are handled. A read on the edge that would set the flag, or on the two edges after it, changes whether the flag is set and whether an interrupt is raised that frame. A write that turns the interrupt enable on during vertical blank, while the flag is still set, raises a late interrupt.

On odd frames with rendering enabled, the pre-render line is one dot shorter. Two event inputs from the rendering logic set the sprite-zero-hit and sprite-overflow bits.

Top module: `vblank_timing_gen`

## Requirements
- R1: Reset (synchronous, active high) puts the raster at line LINES_PER_FRAME-1 (the pre-render line), dot 0, with the status byte 0x00 and `nmi_req` low. The dot counts from 0 to DOTS_PER_LINE-1, wraps to 0 and advances the line. The line wraps from the pre-render line to 0.
- R2: The edge that handles line VBL_LINE, dot 1 sets status bit 7 (the vblank flag), unless R3 applies. The flag then stays set until a read or the R6 clear.
- R3: A status read handled on the line VBL_LINE, dot 1 edge returns bit 7 as 0. It keeps the flag clear and suppresses that frame's interrupt.
- R4: A status read handled at line VBL_LINE, dot 2 or dot 3 returns bit 7 as 1 and clears the flag. No frame interrupt is raised. A read at dot 0 or dot 4 does not suppress the interrupt.
- R5: The frame interrupt is a one-cycle `nmi_req` pulse raised by the edge that handles line VBL_LINE, dot 3. It is therefore seen while the raster shows dot 4. It needs control bit 7 (interrupt enable) set, the flag set, and no read at dots 1 to 3.
- R6: The edge that handles the pre-render line, dot 1 clears status bits 7, 6 and 5.
- R7: Status bits 4..0 equal bits 4..0 of the last control write. Any status read clears bit 7 at its edge.
- R8: A control write that changes bit 7 from 0 to 1 raises `nmi_req` in the next cycle, if the vblank period is active (from line VBL_LINE dot 1 to pre-render dot 1) and the flag is set. Each new 0-to-1 change raises another pulse. No pulse is raised outside that period or once the flag has been read clear.
- R9: On an odd frame with `render_en` high, the edge that handles pre-render dot DOTS_PER_LINE-2 moves the raster to line 0, dot 0. On even frames, or with `render_en` low, the line runs to its last dot. The odd-frame marker starts even after reset and toggles each time the pre-render line is left.
- R10: A high `hit_set` sets status bit 6 and a high `ovf_set` sets status bit 5. The R6 clear takes priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 7 is interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| render_en | input | 1 | Rendering enabled, sampled as a level |
| hit_set | input | 1 | Sets the sprite-zero-hit status bit |
| ovf_set | input | 1 | Sets the sprite-overflow status bit |
| stat_data | output | 8 | Status byte as it reads this cycle |
| nmi_req | output | 1 | One-cycle interrupt request |
| scanline | output | CNT_W | Current line |
| dot | output | CNT_W | Current dot in the line |

## Verification
The bench builds the block with 20 dots per line, 14 lines per frame and vertical blank starting on line 10. With these values a full frame takes 280 cycles. This puts a status read at each dot from 0 to 4 of the vblank line within reach, with one frame for each read position. It also covers several late-enable toggles, the pre-render clear, and both parities of the short odd frame within a few thousand cycles. The bench keeps its own raster model and compares the interrupt position and the flag state against it.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

    typedef struct packed {
        logic vbl;
        logic hit;
        logic ovf;
    } stat_flags_t;

    typedef enum logic [1:0] {
        RD_NONE  = 2'd0,
        RD_EARLY = 2'd1,
        RD_LATE  = 2'd2
    } rd_mark_e;

    localparam int LOW_BITS = 5;

    function automatic logic [7:0] pack_status(stat_flags_t f, logic [LOW_BITS-1:0] low);
        return {f.vbl, f.hit, f.ovf, low};
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int CNT_W           = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             render_en,
    output logic [CNT_W-1:0] line,
    output logic [CNT_W-1:0] dot,
    output logic             odd
);
    localparam logic [CNT_W-1:0] LAST_DOT  = CNT_W'(DOTS_PER_LINE - 1);
    localparam logic [CNT_W-1:0] SKIP_DOT  = CNT_W'(DOTS_PER_LINE - 2);
    localparam logic [CNT_W-1:0] PRE_LINE  = CNT_W'(LINES_PER_FRAME - 1);

    logic on_pre;
    logic short_line;

    always_comb begin
        on_pre     = (line == PRE_LINE);
        short_line = on_pre && (dot == SKIP_DOT) && odd && render_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= PRE_LINE;
            dot  <= '0;
            odd  <= 1'b0;
        end else if (short_line) begin
            line <= '0;
            dot  <= '0;
            odd  <= ~odd;
        end else if (dot == LAST_DOT) begin
            dot <= '0;
            if (on_pre) begin
                line <= '0;
                odd  <= ~odd;
            end else begin
                line <= line + 1'b1;
            end
        end else begin
            dot <= dot + 1'b1;
        end
    end
endmodule

// File: rtl/vblank_status.sv
module vblank_status
    import vbt_pkg::*;
#(
    parameter int LINES_PER_FRAME = 262,
    parameter int VBL_LINE        = 241,
    parameter int CNT_W           = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    line,
    input  logic [CNT_W-1:0]    dot,
    input  logic                stat_rd,
    input  logic                ctrl_wr,
    input  logic [LOW_BITS-1:0] wr_low,
    input  logic                hit_set,
    input  logic                ovf_set,
    output stat_flags_t         flags,
    output logic [LOW_BITS-1:0] io_low,
    output logic                vbl_active,
    output rd_mark_e            rd_mark
);
    localparam logic [CNT_W-1:0] VBL_L = CNT_W'(VBL_LINE);
    localparam logic [CNT_W-1:0] PRE_L = CNT_W'(LINES_PER_FRAME - 1);

    logic on_vbl, at_set, at_clr;

    always_comb begin
        on_vbl = (line == VBL_L);
        at_set = on_vbl && (dot == CNT_W'(1));
        at_clr = (line == PRE_L) && (dot == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            vbl_active <= 1'b0;
            rd_mark    <= RD_NONE;
            io_low     <= '0;
        end else begin
            if (at_clr) begin
                flags <= '0;
            end else begin
                if (at_set && !stat_rd) flags.vbl <= 1'b1;
                else if (stat_rd)       flags.vbl <= 1'b0;
                if (hit_set) flags.hit <= 1'b1;
                if (ovf_set) flags.ovf <= 1'b1;
            end

            if (at_clr)      vbl_active <= 1'b0;
            else if (at_set) vbl_active <= 1'b1;

            if (on_vbl) begin
                if (dot == CNT_W'(3))
                    rd_mark <= RD_NONE;
                else if (stat_rd && dot == CNT_W'(1))
                    rd_mark <= RD_EARLY;
                else if (stat_rd && dot == CNT_W'(2) && rd_mark == RD_NONE)
                    rd_mark <= RD_LATE;
            end

            if (ctrl_wr) io_low <= wr_low;
        end
    end
endmodule

// File: rtl/nmi_gen.sv
module nmi_gen
    import vbt_pkg::*;
#(
    parameter int VBL_LINE = 241,
    parameter int CNT_W    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] line,
    input  logic [CNT_W-1:0] dot,
    input  logic             stat_rd,
    input  logic             ctrl_wr,
    input  logic             wr_enable,
    input  logic             vbl_flag,
    input  logic             vbl_active,
    input  rd_mark_e         rd_mark,
    output logic             nmi_en,
    output logic             nmi_req
);
    localparam logic [CNT_W-1:0] VBL_L = CNT_W'(VBL_LINE);

    logic frame_nmi, late_nmi;

    always_comb begin
        frame_nmi = (line == VBL_L) && (dot == CNT_W'(3)) && (rd_mark == RD_NONE)
                    && !stat_rd && vbl_flag && nmi_en;
        late_nmi  = ctrl_wr && wr_enable && !nmi_en && vbl_active && vbl_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_en  <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            nmi_req <= frame_nmi || late_nmi;
            if (ctrl_wr) nmi_en <= wr_enable;
        end
    end
endmodule

// File: rtl/vblank_timing_gen.sv
module vblank_timing_gen
    import vbt_pkg::*;
#(
    parameter int  DOTS_PER_LINE   = 341,
    parameter int  LINES_PER_FRAME = 262,
    parameter int  VBL_LINE        = 241,
    localparam int CNT_W = $clog2((DOTS_PER_LINE > LINES_PER_FRAME) ? DOTS_PER_LINE : LINES_PER_FRAME)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    input  logic             stat_rd,
    input  logic             render_en,
    input  logic             hit_set,
    input  logic             ovf_set,
    output logic [7:0]       stat_data,
    output logic             nmi_req,
    output logic [CNT_W-1:0] scanline,
    output logic [CNT_W-1:0] dot
);
    stat_flags_t         flags;
    logic [LOW_BITS-1:0] io_low;
    logic                vbl_active;
    logic                nmi_en;
    logic                odd_frame;
    rd_mark_e            rd_mark;

    raster_counter #(
        .DOTS_PER_LINE  (DOTS_PER_LINE),
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .CNT_W          (CNT_W)
    ) u_raster (
        .clk      (clk),
        .rst      (rst),
        .render_en(render_en),
        .line     (scanline),
        .dot      (dot),
        .odd      (odd_frame)
    );

    vblank_status #(
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .VBL_LINE       (VBL_LINE),
        .CNT_W          (CNT_W)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .line      (scanline),
        .dot       (dot),
        .stat_rd   (stat_rd),
        .ctrl_wr   (ctrl_wr),
        .wr_low    (ctrl_wdata[LOW_BITS-1:0]),
        .hit_set   (hit_set),
        .ovf_set   (ovf_set),
        .flags     (flags),
        .io_low    (io_low),
        .vbl_active(vbl_active),
        .rd_mark   (rd_mark)
    );

    nmi_gen #(
        .VBL_LINE(VBL_LINE),
        .CNT_W   (CNT_W)
    ) u_nmi (
        .clk       (clk),
        .rst       (rst),
        .line      (scanline),
        .dot       (dot),
        .stat_rd   (stat_rd),
        .ctrl_wr   (ctrl_wr),
        .wr_enable (ctrl_wdata[7]),
        .vbl_flag  (flags.vbl),
        .vbl_active(vbl_active),
        .rd_mark   (rd_mark),
        .nmi_en    (nmi_en),
        .nmi_req   (nmi_req)
    );

    assign stat_data = pack_status(flags, io_low);
endmodule

// File: rtl/vbt_checker.sv
module vbt_checker #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBL_LINE        = 241,
    parameter int CNT_W           = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             ctrl_wr,
    input logic             wr_enable,
    input logic             stat_rd,
    input logic             render_en,
    input logic [7:0]       stat_data,
    input logic             nmi_req,
    input logic [CNT_W-1:0] scanline,
    input logic [CNT_W-1:0] dot,
    input logic             odd_frame,
    input logic             nmi_en,
    input logic             vbl_active
);
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DOTS_PER_LINE - 1);
    localparam logic [CNT_W-1:0] SKIP_D = CNT_W'(DOTS_PER_LINE - 2);
    localparam logic [CNT_W-1:0] PRE_L  = CNT_W'(LINES_PER_FRAME - 1);
    localparam logic [CNT_W-1:0] VBL_L  = CNT_W'(VBL_LINE);

    // R1
    dot_range_chk: assert property (@(posedge clk) disable iff (rst)
        dot <= LAST_D);

    // R1
    dot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (dot == LAST_D) |=> (dot == '0));

    // R2
    vbl_set_chk: assert property (@(posedge clk) disable iff (rst)
        (scanline == VBL_L && dot == CNT_W'(1) && !stat_rd) |=> stat_data[7]);

    // R3
    early_read_chk: assert property (@(posedge clk) disable iff (rst)
        (scanline == VBL_L && dot == CNT_W'(1) && stat_rd) |=> !stat_data[7]);

    // R5
    nmi_place_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !$past(ctrl_wr)) |-> (scanline == VBL_L && dot == CNT_W'(4)));

    // R6
    pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (scanline == PRE_L && dot == CNT_W'(1)) |=> (stat_data[7:5] == 3'b000));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> !stat_data[7]);

    // R8
    late_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_enable && !nmi_en && vbl_active && stat_data[7]) |=> nmi_req);

    // R9
    odd_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (scanline == PRE_L && dot == SKIP_D && odd_frame && render_en)
        |=> (scanline == '0 && dot == '0));
endmodule

bind vblank_timing_gen vbt_checker #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .VBL_LINE       (VBL_LINE),
    .CNT_W          (CNT_W)
) u_vbt_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .wr_enable (ctrl_wdata[7]),
    .stat_rd   (stat_rd),
    .render_en (render_en),
    .stat_data (stat_data),
    .nmi_req   (nmi_req),
    .scanline  (scanline),
    .dot       (dot),
    .odd_frame (odd_frame),
    .nmi_en    (nmi_en),
    .vbl_active(vbl_active)
);

// File: tb/vblank_timing_gen_bench.sv
`timescale 1ns/1ps
module vblank_timing_gen_bench;
    localparam int DOTS  = 20;
    localparam int LINES = 14;
    localparam int VBL   = 10;
    localparam int PRE   = LINES - 1;
    localparam int W     = $clog2(DOTS);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctrl_wr = 1'b0;
    logic [7:0]   ctrl_wdata = 8'h00;
    logic         stat_rd = 1'b0;
    logic         render_en = 1'b0;
    logic         hit_set = 1'b0;
    logic         ovf_set = 1'b0;
    logic [7:0]   stat_data;
    logic         nmi_req;
    logic [W-1:0] scanline;
    logic [W-1:0] dot;

    int checks = 0;
    int errors = 0;
    int ref_line = PRE;
    int ref_dot = 0;
    bit ref_odd = 1'b0;
    int pos_err = 0;
    int nmi_cnt = 0;
    int nmi_line = -1;
    int nmi_dot = -1;

    always #2.5 clk = ~clk;

    vblank_timing_gen #(
        .DOTS_PER_LINE  (DOTS),
        .LINES_PER_FRAME(LINES),
        .VBL_LINE       (VBL)
    ) u_vblank_timing_gen (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_wdata(ctrl_wdata),
        .stat_rd   (stat_rd),
        .render_en (render_en),
        .hit_set   (hit_set),
        .ovf_set   (ovf_set),
        .stat_data (stat_data),
        .nmi_req   (nmi_req),
        .scanline  (scanline),
        .dot       (dot)
    );

    // independent raster model and monitors, all sampling pre-edge values
    always @(posedge clk) begin
        if (!rst) begin
            if (int'(scanline) != ref_line || int'(dot) != ref_dot) pos_err <= pos_err + 1;
            if (nmi_req) begin
                nmi_cnt  <= nmi_cnt + 1;
                nmi_line <= int'(scanline);
                nmi_dot  <= int'(dot);
            end
        end
        if (rst) begin
            ref_line <= PRE; ref_dot <= 0; ref_odd <= 1'b0;
        end else if (ref_line == PRE && ref_dot == DOTS - 2 && ref_odd && render_en) begin
            ref_line <= 0; ref_dot <= 0; ref_odd <= ~ref_odd;
        end else if (ref_dot == DOTS - 1) begin
            ref_dot <= 0;
            if (ref_line == PRE) begin ref_line <= 0; ref_odd <= ~ref_odd; end
            else ref_line <= ref_line + 1;
        end else begin
            ref_dot <= ref_dot + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_to(input int l, input int d);
        @(negedge clk);
        while (!(ref_line == l && ref_dot == d)) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset line", int'(scanline), PRE);
        chk("R1 reset dot", int'(dot), 0);
        chk("R1 reset status", int'(stat_data), 0);
        chk("R1 reset nmi", int'(nmi_req), 0);
    endtask

    task automatic t_counter();
        go_to(3, DOTS - 1);
        @(negedge clk);
        chk("R1 dot wrap line", int'(scanline), 4);
        chk("R1 dot wrap dot", int'(dot), 0);
        go_to(PRE, DOTS - 1);
        @(negedge clk);
        chk("R1 frame wrap line", int'(scanline), 0);
        chk("R1 frame wrap dot", int'(dot), 0);
    endtask

    // read at line VBL, dot d; R3 for d=1, R4 otherwise
    task automatic t_read_case(input int d, input int exp_rd7, input int exp_flag, input int exp_nmi);
        int rd7;
        go_to(2, 0);
        write_ctrl(8'h80);
        go_to(VBL - 1, 0);
        nmi_cnt = 0;
        go_to(VBL, d);
        stat_rd = 1'b1;
        rd7 = int'(stat_data[7]);
        @(negedge clk);
        stat_rd = 1'b0;
        go_to(VBL, 6);
        chk($sformatf("R3/R4 read value at dot %0d", d), rd7, exp_rd7);
        chk($sformatf("R3/R4 flag after read at dot %0d", d), int'(stat_data[7]), exp_flag);
        chk($sformatf("R5 nmi count, read at dot %0d", d), nmi_cnt, exp_nmi);
        if (exp_nmi != 0) begin
            chk("R5 nmi line", nmi_line, VBL);
            chk("R5 nmi dot", nmi_dot, 4);
        end
    endtask

    task automatic t_pre_clear();
        go_to(VBL, 6);
        chk("R2 flag set without read", int'(stat_data[7]), 1);
        hit_set = 1'b1; ovf_set = 1'b1;
        @(negedge clk);
        hit_set = 1'b0; ovf_set = 1'b0;
        chk("R10 sprite bits set", int'(stat_data[7:5]), 7);
        go_to(PRE, 1);
        chk("R6 bits held before dot 1", int'(stat_data[7:5]), 7);
        @(negedge clk);
        chk("R6 bits cleared", int'(stat_data[7:5]), 0);
    endtask

    task automatic t_low_bits();
        go_to(1, 0);
        write_ctrl(8'h15);
        chk("R7 low bits follow write", int'(stat_data[4:0]), 5'h15);
        go_to(VBL, 8);
        stat_rd = 1'b1;
        chk("R7 read value", int'(stat_data), 8'h95);
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R7 read clears bit 7", int'(stat_data), 8'h15);
    endtask

    task automatic t_late_nmi();
        go_to(1, 0);
        write_ctrl(8'h00);
        go_to(VBL - 1, 0);
        nmi_cnt = 0;
        go_to(VBL, 6);
        chk("R5 no frame nmi when disabled", nmi_cnt, 0);
        write_ctrl(8'h80);
        chk("R8 late nmi next cycle", int'(nmi_req), 1);
        write_ctrl(8'h00);
        write_ctrl(8'h80);
        write_ctrl(8'h80);
        @(negedge clk);
        chk("R8 one pulse per rising enable", nmi_cnt, 2);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        write_ctrl(8'h00);
        write_ctrl(8'h80);
        @(negedge clk);
        chk("R8 no late nmi after flag read", nmi_cnt, 2);
        go_to(3, 0);
        nmi_cnt = 0;
        write_ctrl(8'h00);
        write_ctrl(8'h80);
        @(negedge clk);
        chk("R8 no late nmi outside vblank", nmi_cnt, 0);
    endtask

    task automatic t_skip(input logic ren);
        int exp_skip;
        render_en = ren;
        go_to(PRE, DOTS - 2);
        exp_skip = (ref_odd && ren) ? 1 : 0;
        @(negedge clk);
        if (exp_skip != 0) begin
            chk("R9 odd frame skip line", int'(scanline), 0);
            chk("R9 odd frame skip dot", int'(dot), 0);
        end else begin
            chk("R9 full line kept", int'(dot), DOTS - 1);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_counter();
        t_read_case(0, 0, 1, 1);
        t_read_case(1, 0, 0, 0);
        t_read_case(2, 1, 0, 0);
        t_read_case(3, 1, 0, 0);
        t_read_case(4, 1, 0, 1);
        t_pre_clear();
        t_low_bits();
        t_late_nmi();
        t_skip(1'b1);
        t_skip(1'b1);
        t_skip(1'b0);
        t_skip(1'b0);
        render_en = 1'b0;
        chk("R1 raster matches model", pos_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule